// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block generates the raster timing for a parallel RGB panel: horizontal and vertical sync strobes, a data-enable flag that marks the visible area, and the pixel column and row inside that area. It also produces a pixel-clock enable strobe and a pixel-clock waveform derived from the system clock by a programmable ratio. All timing comes from 32-bit words written over a simple write-only register bus.

Timing words are double-buffered. Software may rewrite the shadow copies at any moment. The live set changes only on the last pixel of a frame, so a frame is never drawn with mixed settings. A commit happens either once, on request, or on every frame when automatic update is enabled. When the raster is disabled, the counters stay at zero and a pending commit lands at once. A built-in test pattern splits the visible width into equal vertical bars. Each bar takes its colour from its own register. In the other display modes the pixel output is black.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts pulse+back+16*W+front pixel ticks, with sync first, then back porch, then W*16 active pixels, then front porch. The horizontal word at address 2 holds back porch in bits 31:22, pulse in bits 21:11 and front porch in bits 10:0. Pulse 96, back 48, front 16 and W=40 give 800 ticks.
- R2: The vertical word at address 3 uses the same layout, counted in lines. vsync is active during the first pulse lines of a frame. The vertical counter advances once per completed line.
- R3: The size word at address 1 holds the active line count in bits 31:16 and W, the active width divided by 16, in bits 15:0.
- R4: The divider word at address 5 holds N. pix_ce pulses once every N+1 clocks while the raster runs.
- R5: In the polarity word at address 4, bit 0 makes hsync active-low and bit 1 makes vsync active-low. Otherwise both are active-high.
- R6: pclk_o is high in the cycle of each pix_ce. In the cycle after pix_ce it is low, or high when N=0. Polarity bit 6 inverts pclk_o.
- R7: Writes to addresses 1 to 5 change nothing until a commit. Setting bit 30 of the update word at address 6 requests a single commit on the last pixel of the current frame, and the request then clears itself.
- R8: Bit 31 of the update word commits the shadow set on every frame's last pixel.
- R9: While raster enable (bit 14 of the mode word at address 0) is low, pix_ce, de_o, px_x, px_y and rgb_o are 0 and the syncs sit at their inactive levels. A pending commit takes effect at once. The first tick after enabling is pixel (0,0) of a new frame.
- R10: When mode bits 1:0 equal 3, the active width is split into 8 bars of 2*W pixels. Bar i shows the 24-bit colour written to address 8+i. Other modes output 0.
- R11: px_x and px_y give the position inside the active area while de_o is high and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | One-cycle pixel tick |
| pclk_o | output | 1 | Pixel clock waveform for the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Active-area flag |
| px_x | output | CNT_W | Active column |
| px_y | output | CNT_W | Active row |
| rgb_o | output | 24 | Pixel colour (test bars or black) |

## Verification
A corrupted horizontal counter shows up within one line: the sync, data-enable or column values on a pixel tick stop matching their position in the line. A corrupted vertical counter shows up as a row or vsync mismatch at the next line boundary. A commit that lands on the wrong edge, or a request that fails to clear, changes line length, polarity or divider spacing in the first pixel tick of the affected frame. A wrong bar index shows up as a wrong colour at the first active pixel of the affected bar.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
   // timing word: fields decoded by the axis counters, bit order is fixed
   typedef struct packed {
      logic [9:0]  back;
      logic [10:0] pulse;
      logic [10:0] front;
   } sync_word_t;

   localparam int unsigned ADR_MODE = 0;
   localparam int unsigned ADR_SIZE = 1;
   localparam int unsigned ADR_HTIM = 2;
   localparam int unsigned ADR_VTIM = 3;
   localparam int unsigned ADR_POL  = 4;
   localparam int unsigned ADR_DIV  = 5;
   localparam int unsigned ADR_UPD  = 6;
   localparam int unsigned ADR_BAR0 = 8;

   localparam int unsigned RASTER_BIT = 14;
   localparam int unsigned PCLK_INV_BIT = 6;
   localparam int unsigned REQ_BIT = 30;
   localparam int unsigned AUTO_BIT = 31;
   localparam logic [1:0]  DM_BARS = 2'd3;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
   import lcd_tg_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 16,
   parameter int DIV_W    = 8,
   parameter int NUM_BARS = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [31:0]              wdata,
   input  logic                     frame_end,
   output logic                     raster_en,
   output logic [1:0]               disp_mode,
   output logic [CNT_W-5:0]         width16,
   output logic [CNT_W-1:0]         height,
   output sync_word_t               htim,
   output sync_word_t               vtim,
   output logic                     pol_h,
   output logic                     pol_v,
   output logic                     pclk_inv,
   output logic [DIV_W-1:0]         div_m1,
   output logic [NUM_BARS*24-1:0]   col_flat
);
   localparam int ACT_W = CNT_W - 4;

   logic [ACT_W-1:0] sh_w16;
   logic [CNT_W-1:0] sh_height;
   sync_word_t       sh_h, sh_v;
   logic [2:0]       sh_pol;
   logic [DIV_W-1:0] sh_div;
   logic             req_q, auto_q;
   logic             commit, upd_wr;

   assign upd_wr = wr && (addr == ADDR_W'(ADR_UPD));
   assign commit = (req_q || auto_q) && (frame_end || !raster_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raster_en <= 1'b0;
         disp_mode <= '0;
         sh_w16    <= '0;
         sh_height <= '0;
         sh_h      <= '0;
         sh_v      <= '0;
         sh_pol    <= '0;
         sh_div    <= '0;
         req_q     <= 1'b0;
         auto_q    <= 1'b0;
      end else begin
         if (commit) req_q <= 1'b0;
         if (wr) begin
            if (addr == ADDR_W'(ADR_MODE)) begin
               raster_en <= wdata[RASTER_BIT];
               disp_mode <= wdata[1:0];
            end
            if (addr == ADDR_W'(ADR_SIZE)) begin
               sh_w16    <= wdata[ACT_W-1:0];
               sh_height <= wdata[16 +: CNT_W];
            end
            if (addr == ADDR_W'(ADR_HTIM)) sh_h <= sync_word_t'(wdata);
            if (addr == ADDR_W'(ADR_VTIM)) sh_v <= sync_word_t'(wdata);
            if (addr == ADDR_W'(ADR_POL))
               sh_pol <= {wdata[PCLK_INV_BIT], wdata[1], wdata[0]};
            if (addr == ADDR_W'(ADR_DIV)) sh_div <= wdata[DIV_W-1:0];
            if (upd_wr) begin
               auto_q <= wdata[AUTO_BIT];
               req_q  <= wdata[REQ_BIT];
            end
         end
      end
   end

   // live set, loaded only at a commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width16  <= '0;
         height   <= '0;
         htim     <= '0;
         vtim     <= '0;
         {pclk_inv, pol_v, pol_h} <= '0;
         div_m1   <= '0;
      end else if (commit) begin
         width16  <= sh_w16;
         height   <= sh_height;
         htim     <= sh_h;
         vtim     <= sh_v;
         {pclk_inv, pol_v, pol_h} <= sh_pol;
         div_m1   <= sh_div;
      end
   end

   for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) col_flat[g*24 +: 24] <= '0;
         else if (wr && addr == ADDR_W'(ADR_BAR0 + g)) col_flat[g*24 +: 24] <= wdata[23:0];
      end
   end

   // R7: a serviced request does not survive its commit
   assert_req_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !upd_wr) |=> !req_q);
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] ratio_m1,
   input  logic             inv,
   output logic             pix_ce,
   output logic             pclk_o
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   half;

   assign half   = ({1'b0, ratio_m1} + (DIV_W+1)'(1)) >> 1;
   assign pix_ce = en && (cnt >= ratio_m1);
   assign pclk_o = ({1'b0, cnt} >= half) ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!en || cnt >= ratio_m1)    cnt <= '0;
      else                                cnt <= cnt + DIV_W'(1);
   end

   // R4: ticks are spaced by the programmed ratio
   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ce |=> (ratio_m1 == '0 || !pix_ce));
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> cnt <= ratio_m1);
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [10:0]      pulse,
   input  logic [9:0]       back,
   input  logic [10:0]      front,
   input  logic [CNT_W-1:0] act,
   output logic             last,
   output logic             sync_on,
   output logic             active,
   output logic [CNT_W-1:0] pos
);
   localparam int TW = CNT_W + 2;

   logic [TW-1:0] cnt, act_lo, act_hi, total;

   always_comb begin
      act_lo = TW'(pulse) + TW'(back);
      act_hi = act_lo + TW'(act);
      total  = act_hi + TW'(front);
   end

   assign last    = (cnt + TW'(1)) >= total;
   assign sync_on = cnt < TW'(pulse);
   assign active  = (cnt >= act_lo) && (cnt < act_hi);
   assign pos     = active ? CNT_W'(cnt - act_lo) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!en)    cnt <= '0;
      else if (step)   cnt <= last ? '0 : cnt + TW'(1);
   end

   // R1 (line length) / R2 (frame length): count stays inside its period
   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && total != '0) |-> cnt < total);
endmodule

// File: rtl/lcd_tg_bars.sv
module lcd_tg_bars #(
   parameter int ACT_W    = 12,
   parameter int NUM_BARS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pix_ce,
   input  logic                   de,
   input  logic                   line_last,
   input  logic                   show,
   input  logic [ACT_W-1:0]       width16,
   input  logic [NUM_BARS*24-1:0] col_flat,
   output logic [23:0]            rgb
);
   localparam int IW    = $clog2(NUM_BARS);
   localparam int SHIFT = 4 - IW;
   localparam int SUBW  = ACT_W + 4;

   logic [SUBW-1:0] bar_w, sub;
   logic [IW-1:0]   idx;
   logic [23:0]     col_arr [NUM_BARS];

   for (genvar g = 0; g < NUM_BARS; g++) begin : g_col
      assign col_arr[g] = col_flat[g*24 +: 24];
   end

   assign bar_w = SUBW'(width16) << SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub <= '0;
         idx <= '0;
      end else if (!de) begin
         sub <= '0;
         idx <= '0;
      end else if (pix_ce) begin
         if (line_last) begin
            sub <= '0;
            idx <= '0;
         end else if (sub == bar_w - SUBW'(1)) begin
            sub <= '0;
            idx <= idx + IW'(1);
         end else begin
            sub <= sub + SUBW'(1);
         end
      end
   end

   assign rgb = (show && de) ? col_arr[idx] : 24'h0;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DIV_W    = 8,
   parameter int NUM_BARS = 8,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              pix_ce,
   output logic              pclk_o,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [CNT_W-1:0]  px_x,
   output logic [CNT_W-1:0]  px_y,
   output logic [23:0]       rgb_o
);
   localparam int ACT_W = CNT_W - 4;

   if (CNT_W < 12 || CNT_W > 16) begin : g_bad_cnt_w
      $error("CNT_W must lie in 12..16");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div_w
      $error("DIV_W must lie in 1..32");
   end
   if (NUM_BARS != 2 && NUM_BARS != 4 && NUM_BARS != 8 && NUM_BARS != 16) begin : g_bad_bars
      $error("NUM_BARS must be 2, 4, 8 or 16");
   end
   if (ADR_BAR0 + NUM_BARS > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the bar colour registers");
   end

   logic                   raster_en, pol_h, pol_v, pclk_inv;
   logic [1:0]             disp_mode;
   logic [ACT_W-1:0]       width16;
   logic [CNT_W-1:0]       height;
   sync_word_t             htim, vtim;
   logic [DIV_W-1:0]       div_m1;
   logic [NUM_BARS*24-1:0] col_flat;
   logic                   h_last, v_last, h_sync, v_sync, h_act, v_act, frame_end;
   logic [CNT_W-1:0]       hpos, vpos;

   assign frame_end = pix_ce && h_last && v_last;

   lcd_tg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .NUM_BARS(NUM_BARS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .frame_end(frame_end), .raster_en(raster_en), .disp_mode(disp_mode),
      .width16(width16), .height(height), .htim(htim), .vtim(vtim),
      .pol_h(pol_h), .pol_v(pol_v), .pclk_inv(pclk_inv), .div_m1(div_m1),
      .col_flat(col_flat)
   );

   lcd_tg_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(raster_en), .ratio_m1(div_m1), .inv(pclk_inv),
      .pix_ce(pix_ce), .pclk_o(pclk_o)
   );

   lcd_tg_axis #(.CNT_W(CNT_W)) u_hor (
      .clk(clk), .rst_n(rst_n), .en(raster_en), .step(pix_ce),
      .pulse(htim.pulse), .back(htim.back), .front(htim.front),
      .act({width16, 4'b0000}),
      .last(h_last), .sync_on(h_sync), .active(h_act), .pos(hpos)
   );

   lcd_tg_axis #(.CNT_W(CNT_W)) u_ver (
      .clk(clk), .rst_n(rst_n), .en(raster_en), .step(pix_ce && h_last),
      .pulse(vtim.pulse), .back(vtim.back), .front(vtim.front),
      .act(height),
      .last(v_last), .sync_on(v_sync), .active(v_act), .pos(vpos)
   );

   assign de_o    = raster_en && h_act && v_act;
   assign hsync_o = (raster_en && h_sync) ^ pol_h;
   assign vsync_o = (raster_en && v_sync) ^ pol_v;
   assign px_x    = de_o ? hpos : '0;
   assign px_y    = de_o ? vpos : '0;

   lcd_tg_bars #(.ACT_W(ACT_W), .NUM_BARS(NUM_BARS)) u_bars (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .de(de_o), .line_last(h_last),
      .show(disp_mode == DM_BARS), .width16(width16), .col_flat(col_flat),
      .rgb(rgb_o)
   );

   // R1/R2: the visible area never overlaps a sync pulse
   assert_de_outside_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> (hsync_o == pol_h && vsync_o == pol_v));
   // R9: a stopped raster emits no ticks and no visible pixels
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !raster_en |-> (!pix_ce && !de_o && rgb_o == 24'h0));
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        pix_ce, pclk_o, hsync_o, vsync_o, de_o;
   logic [15:0] px_x, px_y;
   logic [23:0] rgb_o;

   always #5 clk = ~clk;

   lcd_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .pix_ce(pix_ce), .pclk_o(pclk_o),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .px_x(px_x), .px_y(px_y), .rgb_o(rgb_o)
   );

   typedef struct {
      bit hs, vs, de, inv;
      int x, y, rgb, div, tag;
   } item_t;

   item_t q[$];
   int  errors = 0, checks = 0, popped = 0, gap = 0;
   bit  gap_ok = 0, chk_after = 0, done = 0;
   int  hp, hb, hf, w16, vp, vb, vf, hgt, divn;
   bit  polh, polv, inv, bars;

   function automatic int colour(int i);
      return (i * 32'h001F0D07 + 32'h00102030) & 32'h00FFFFFF;
   endfunction

   task automatic check(bit ok, string req, string what, int got, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic load_shadow();
      wr(1, (hgt << 16) | w16);
      wr(2, (hb << 22) | (hp << 11) | hf);
      wr(3, (vb << 22) | (vp << 11) | vf);
      wr(4, int'(polh) | (int'(polv) << 1) | (int'(inv) << 6));
      wr(5, divn);
   endtask

   // driver: expected tick-by-tick outputs of one frame, from the requirements
   task automatic push_frame(int tag);
      int ht = hp + hb + 16 * w16 + hf;
      int vt = vp + vb + hgt + vf;
      int bw = 2 * w16;
      for (int v = 0; v < vt; v++) begin
         for (int h = 0; h < ht; h++) begin
            item_t it;
            bit da;
            da = (h >= hp + hb) && (h < hp + hb + 16 * w16) && (v >= vp + vb) && (v < vp + vb + hgt);
            it.hs  = (h < hp) ^ polh;
            it.vs  = (v < vp) ^ polv;
            it.de  = da;
            it.x   = da ? h - hp - hb : 0;
            it.y   = da ? v - vp - vb : 0;
            it.rgb = (da && bars) ? colour((h - hp - hb) / bw) : 0;
            it.div = divn;
            it.inv = inv;
            it.tag = tag;
            q.push_back(it);
         end
      end
   endtask

   // monitor: compare each pixel tick against the scoreboard
   always @(negedge clk) begin
      if (chk_after) begin
         chk_after = 0;
         if (q.size() > 0)
            check(pclk_o == ((q[0].div == 0) ^ q[0].inv), "R6", "pclk after tick",
                  int'(pclk_o), int'((q[0].div == 0) ^ q[0].inv));
      end
      gap++;
      if (pix_ce && q.size() > 0) begin
         item_t it;
         string tg;
         it = q.pop_front();
         tg = $sformatf("R%0d", it.tag);
         check(hsync_o == it.hs, "R1/R5", {tg, " hsync"}, int'(hsync_o), int'(it.hs));
         check(vsync_o == it.vs, "R2/R5", {tg, " vsync"}, int'(vsync_o), int'(it.vs));
         check(de_o == it.de, "R1/R2", {tg, " de"}, int'(de_o), int'(it.de));
         check(int'(px_x) == it.x, "R11", {tg, " x"}, int'(px_x), it.x);
         check(int'(px_y) == it.y, "R11", {tg, " y"}, int'(px_y), it.y);
         check(int'(rgb_o) == it.rgb, "R10", {tg, " rgb"}, int'(rgb_o), it.rgb);
         check(pclk_o == !it.inv, "R6", {tg, " pclk at tick"}, int'(pclk_o), int'(!it.inv));
         if (gap_ok) check(gap == it.div + 1, "R4", {tg, " tick gap"}, gap, it.div + 1);
         gap = 0;
         gap_ok = 1;
         chk_after = 1;
         popped++;
      end else if (pix_ce) begin
         gap = 0;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, got 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state, raster off (R9)
      check(hsync_o == 0, "R9", "reset hsync", int'(hsync_o), 0);
      check(vsync_o == 0, "R9", "reset vsync", int'(vsync_o), 0);
      check(de_o == 0, "R9", "reset de", int'(de_o), 0);
      check(pix_ce == 0, "R9", "reset pix_ce", int'(pix_ce), 0);
      check(rgb_o == 0 && px_x == 0 && px_y == 0, "R9", "reset pixel", int'(rgb_o), 0);
      rst_n = 1'b1;

      // phase 1: config A, request while stopped commits at once (R3, R9)
      hp = 2; hb = 3; hf = 4; w16 = 2; vp = 1; vb = 1; vf = 1; hgt = 3; divn = 1;
      polh = 0; polv = 0; inv = 0; bars = 1;
      for (int i = 0; i < 8; i++) wr(8 + i, colour(i));
      wr(0, 3);
      load_shadow();
      wr(6, 1 << 30);
      push_frame(3);
      push_frame(10);
      gap_ok = 0;
      wr(0, (1 << 14) | 3);
      wait (q.size() == 0);
      wr(0, 3);

      // phase 2: mid-frame request (R7), then request must not persist
      push_frame(7);
      hp = 1; hb = 2; hf = 3; w16 = 1; vp = 2; vb = 1; vf = 2; hgt = 2; divn = 2;
      polh = 1; polv = 1; inv = 1;
      push_frame(7);
      push_frame(7);
      base = popped;
      gap_ok = 0;
      wr(0, (1 << 14) | 3);
      wait (popped >= base + 10);
      load_shadow();
      wr(6, 1 << 30);
      wait (popped >= base + 246 + 5);
      hp = 7; hb = 9; divn = 4; polh = 0;
      load_shadow();
      hp = 1; hb = 2; divn = 2; polh = 1;
      wait (q.size() == 0);
      wr(0, 3);
      repeat (3) @(negedge clk);
      // R9: stopped raster, live polarity is active-low for both syncs
      check(hsync_o == 1, "R9", "idle hsync level", int'(hsync_o), 1);
      check(vsync_o == 1, "R9", "idle vsync level", int'(vsync_o), 1);
      check(de_o == 0 && pix_ce == 0, "R9", "idle de/tick", int'(de_o) | int'(pix_ce), 0);
      check(px_x == 0 && px_y == 0, "R9", "idle coords", int'(px_x) | int'(px_y), 0);

      // phase 3: automatic update (R8), 640-wide line of 800 ticks (R1)
      wr(6, 1 << 31);
      hp = 2; hb = 3; hf = 4; w16 = 2; vp = 1; vb = 1; vf = 1; hgt = 3; divn = 1;
      polh = 0; polv = 0; inv = 0; bars = 0;
      load_shadow();
      push_frame(8);
      hp = 96; hb = 48; hf = 16; w16 = 40; vp = 1; vb = 0; vf = 0; hgt = 1; divn = 0;
      inv = 1;
      push_frame(1);
      base = popped;
      gap_ok = 0;
      wr(0, (1 << 14) | 1);
      wait (popped >= base + 5);
      load_shadow();
      wait (q.size() == 0);
      check(popped == base + 246 + 1600, "R1", "tick total over two frames", popped - base, 246 + 1600);
      done = 1;
      summary();
      $finish;
   end
endmodule